// File: doc/BRIEF.md
# Phased Ternary Content-Addressable Search Engine

This block holds a small table of `ENTRIES` words. Each word has a stored pattern, a per-bit care mask and a valid flag. A client hands it a key, and it returns which entry holds that key. Two clients share the block. A write client loads, rewrites or invalidates any entry, either right after reset or during normal operation. A search client presents a key and, a fixed number of cycles later, receives a one-cycle completion pulse with the result.

A search is not a single combinational compare. It walks a fixed sequence of phases that mirrors a matchline array. First the key is latched into a search register. Next the searchlines are parked in a neutral state that cannot signal a mismatch, and then every matchline is preset to "match". After that the key is broadcast on the searchlines and each matchline is evaluated against its word. Finally a priority encoder turns the surviving matchlines into an address.

A stored bit whose care flag is clear matches either key value. The `TERNARY` parameter set to 0 gives an exact-match table, with every care flag forced on.

Top module: `tcam_search_engine`

## Requirements
- R1: After reset every entry is invalid, both `wr_ready` and `srch_ready` are 1, and `done`, `hit`, `multi_hit`, `hit_idx` and `match_vec` are 0. A search run on the empty table misses.
- R2: The key is captured on the cycle the search is accepted (`srch_req` and `srch_ready` both 1). Later changes on `srch_key` do not affect that search's result.
- R3: The search runs the phases capture, searchline clear, matchline preset, evaluate and encode. `done` is high for exactly one cycle, on the fifth rising edge after the accepting edge. Both ready outputs are 0 from the accepting edge until the encode phase ends.
- R4: An entry matches only if every bit whose care flag is 1 equals the key bit. A single differing cared bit makes it miss.
- R5: A bit whose care flag is 0 matches key 0 and key 1. Pattern 10XX0 (data 0x10, care 0xF9 in the low byte) matches keys 0x10, 0x12, 0x14 and 0x16, and does not match 0x11 or 0x18.
- R6: An entry written with `wr_valid`=0 never matches, whatever its data holds.
- R7: When several entries match, `hit_idx` is the lowest matching index and `multi_hit` is 1. When exactly one entry matches, `multi_hit` is 0.
- R8: When no entry matches, `hit`, `multi_hit` and `hit_idx` are all 0 at `done`.
- R9: A write is accepted only while the block is idle (`wr_ready`=1); a request made during a search is held until the encode phase has finished. A write accepted on the same edge as a search, or on the edge of the `done` cycle, is seen by that search or by the next one respectively.
- R10: At `done`, bit i of `match_vec` is 1 exactly when entry i matched, and `hit` equals the OR of `match_vec`.
- R11: With `TERNARY`=0 the care mask supplied on a write is ignored and treated as all ones. A word stored with care 0x00 then matches only its exact data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_idx | input | IDXW | Entry to write |
| wr_data | input | WIDTH | Stored pattern |
| wr_care | input | WIDTH | Care mask, 1 = bit compared |
| wr_valid | input | 1 | Valid flag written with the entry |
| srch_req | input | 1 | Search request |
| srch_ready | output | 1 | Search can be accepted this cycle |
| srch_key | input | WIDTH | Search key |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | At least one entry matched |
| multi_hit | output | 1 | More than one entry matched |
| hit_idx | output | IDXW | Lowest matching entry, 0 on a miss |
| match_vec | output | ENTRIES | Per-entry matchline result |

## Verification
A write and a search can both be requested in the same idle cycle. In that case the write must land in the table before the evaluate phase compares against it. The bench provokes this by raising both requests on one edge, with a key equal to the new data, and expects a hit on that entry. It also raises a write while a search is in flight and expects the write to wait until `done`. It then writes in the `done` cycle itself and searches at once: the old key must miss and the new key must hit.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SL_CLEAR,
        PH_ML_PRESET,
        PH_EVAL,
        PH_ENCODE
    } phase_e;

    // One bit cell: a mismatch path exists only when the searchline is driven,
    // the bit is cared for, and stored and search values disagree.
    function automatic logic cell_miss(input logic drive, input logic care,
                                       input logic stored, input logic sl);
        return drive & care & (stored ^ sl);
    endfunction

endpackage

// File: rtl/tcam_phase_ctrl.sv
module tcam_phase_ctrl
    import tcam_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   idle
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:      phase <= start ? PH_SL_CLEAR : PH_IDLE;
                PH_SL_CLEAR:  phase <= PH_ML_PRESET;
                PH_ML_PRESET: phase <= PH_EVAL;
                PH_EVAL:      phase <= PH_ENCODE;
                PH_ENCODE:    phase <= PH_IDLE;
                default:      phase <= PH_IDLE;
            endcase
        end
    end

    assign idle = (phase == PH_IDLE);
endmodule

// File: rtl/tcam_entry_array.sv
module tcam_entry_array #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 8,
    parameter bit TERNARY = 1'b1,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [IDXW-1:0]                 widx,
    input  logic [WIDTH-1:0]                wdata,
    input  logic [WIDTH-1:0]                wcare,
    input  logic                            wvalid,
    output logic [ENTRIES-1:0][WIDTH-1:0]   data_q,
    output logic [ENTRIES-1:0][WIDTH-1:0]   care_q,
    output logic [ENTRIES-1:0]              valid_q
);
    logic [WIDTH-1:0] care_eff;

    generate
        if (TERNARY) begin : g_ternary
            assign care_eff = wcare;
        end else begin : g_binary
            logic unused_care;
            assign unused_care = ^wcare;
            assign care_eff    = '1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[widx] <= wvalid;
            data_q[widx]  <= wdata;
            care_q[widx]  <= care_eff;
        end
    end
endmodule

// File: rtl/tcam_match_plane.sv
module tcam_match_plane
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  phase_e                         phase,
    input  logic [WIDTH-1:0]               key_q,
    input  logic [ENTRIES-1:0][WIDTH-1:0]  data_q,
    input  logic [ENTRIES-1:0][WIDTH-1:0]  care_q,
    input  logic [ENTRIES-1:0]             valid_q,
    output logic [ENTRIES-1:0]             ml
);
    logic [WIDTH-1:0] sl_q;
    logic             sl_drive;

    // Searchline drivers: parked neutral, then broadcast the latched key.
    always_ff @(posedge clk) begin
        if (rst) begin
            sl_q     <= '0;
            sl_drive <= 1'b0;
        end else begin
            case (phase)
                PH_SL_CLEAR: begin
                    sl_q     <= '0;
                    sl_drive <= 1'b0;
                end
                PH_ML_PRESET: begin
                    sl_q     <= key_q;
                    sl_drive <= 1'b1;
                end
                PH_ENCODE: sl_drive <= 1'b0;
                default: ;
            endcase
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_line
        logic [WIDTH-1:0] miss_bits;
        logic             line_q;

        for (genvar b = 0; b < WIDTH; b++) begin : g_cell
            assign miss_bits[b] = cell_miss(sl_drive, care_q[e][b],
                                            data_q[e][b], sl_q[b]);
        end

        always_ff @(posedge clk) begin
            if (rst)
                line_q <= 1'b0;
            else if (phase == PH_ML_PRESET)
                line_q <= 1'b1;
            else if (phase == PH_EVAL)
                line_q <= line_q & ~(|miss_bits) & valid_q[e];
        end

        assign ml[e] = line_q;
    end
endmodule

// File: rtl/tcam_prio_encoder.sv
module tcam_prio_encoder #(
    parameter int ENTRIES = 8,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] lines,
    output logic               any,
    output logic               several,
    output logic [IDXW-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lines[i]) idx = IDXW'(i);
        end
    end

    assign any     = |lines;
    assign several = |(lines & (lines - 1'b1));
endmodule

// File: rtl/tcam_search_engine.sv
module tcam_search_engine
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 8,
    parameter bit TERNARY = 1'b1,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_req,
    output logic                wr_ready,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [WIDTH-1:0]    wr_data,
    input  logic [WIDTH-1:0]    wr_care,
    input  logic                wr_valid,
    input  logic                srch_req,
    output logic                srch_ready,
    input  logic [WIDTH-1:0]    srch_key,
    output logic                done,
    output logic                hit,
    output logic                multi_hit,
    output logic [IDXW-1:0]     hit_idx,
    output logic [ENTRIES-1:0]  match_vec
);
    typedef struct packed {
        logic               hit;
        logic               multi;
        logic [IDXW-1:0]    idx;
        logic [ENTRIES-1:0] vec;
    } result_t;

    phase_e                         phase;
    logic                           idle;
    logic                           srch_go;
    logic                           wr_go;
    logic [WIDTH-1:0]               key_q;
    logic [ENTRIES-1:0][WIDTH-1:0]  data_q;
    logic [ENTRIES-1:0][WIDTH-1:0]  care_q;
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             ml;
    result_t                        enc;
    result_t                        res_q;

    assign srch_go    = srch_req & idle;
    assign wr_go      = wr_req & idle;
    assign srch_ready = idle;
    assign wr_ready   = idle;

    tcam_phase_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (srch_go),
        .phase (phase),
        .idle  (idle)
    );

    always_ff @(posedge clk) begin
        if (rst)          key_q <= '0;
        else if (srch_go) key_q <= srch_key;
    end

    tcam_entry_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .TERNARY(TERNARY)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_go),
        .widx    (wr_idx),
        .wdata   (wr_data),
        .wcare   (wr_care),
        .wvalid  (wr_valid),
        .data_q  (data_q),
        .care_q  (care_q),
        .valid_q (valid_q)
    );

    tcam_match_plane #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_plane (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .key_q   (key_q),
        .data_q  (data_q),
        .care_q  (care_q),
        .valid_q (valid_q),
        .ml      (ml)
    );

    tcam_prio_encoder #(.ENTRIES(ENTRIES)) u_enc (
        .lines   (ml),
        .any     (enc.hit),
        .several (enc.multi),
        .idx     (enc.idx)
    );
    assign enc.vec = ml;

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            res_q <= '0;
        end else begin
            done <= (phase == PH_ENCODE);
            if (phase == PH_ENCODE) res_q <= enc;
        end
    end

    assign hit       = res_q.hit;
    assign multi_hit = res_q.multi;
    assign hit_idx   = res_q.idx;
    assign match_vec = res_q.vec;
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk #(
    parameter int ENTRIES = 8,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_ready,
    input logic                srch_req,
    input logic                srch_ready,
    input logic                done,
    input logic                hit,
    input logic                multi_hit,
    input logic [IDXW-1:0]     hit_idx,
    input logic [ENTRIES-1:0]  match_vec
);
    logic [ENTRIES-1:0] below;
    always_comb begin
        below = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (i < int'(hit_idx)) below[i] = 1'b1;
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (srch_req && srch_ready) |=> ##4 done);

    // R9
    busy_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (srch_req && srch_ready) |=> (!srch_ready && !wr_ready));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (hit_idx == '0 && !multi_hit));

    // R7
    multi_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (multi_hit == ($countones(match_vec) > 1)));

    // R7
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (match_vec[hit_idx] && ((match_vec & below) == '0)));

    // R10
    hit_vec_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (hit == (match_vec != '0)));
endmodule

bind tcam_search_engine tcam_search_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_ready   (wr_ready),
    .srch_req   (srch_req),
    .srch_ready (srch_ready),
    .done       (done),
    .hit        (hit),
    .multi_hit  (multi_hit),
    .hit_idx    (hit_idx),
    .match_vec  (match_vec)
);

// File: tb/sim_tcam_search_engine.sv
`timescale 1ns/1ps
module sim_tcam_search_engine;
    localparam int N = 8;
    localparam int W = 8;

    typedef struct {
        logic       hit;
        logic       multi;
        logic [2:0] idx;
        logic [7:0] vec;
        int         due;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         wr_req = 0, wr_valid = 0, srch_req = 0;
    logic [2:0]   wr_idx = 0;
    logic [W-1:0] wr_data = 0, wr_care = 0, srch_key = 0;
    logic         wr_ready, srch_ready, done, hit, multi_hit;
    logic [2:0]   hit_idx;
    logic [N-1:0] match_vec;

    logic         b_wr_req = 0, b_srch_req = 0;
    logic [W-1:0] b_wr_data = 0, b_wr_care = 0, b_key = 0;
    logic         b_wr_ready, b_srch_ready, b_done, b_hit, b_multi;
    logic [2:0]   b_idx;
    logic [N-1:0] b_vec;

    tcam_search_engine #(.ENTRIES(N), .WIDTH(W), .TERNARY(1'b1)) u0 (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_ready(wr_ready),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_care(wr_care), .wr_valid(wr_valid),
        .srch_req(srch_req), .srch_ready(srch_ready), .srch_key(srch_key),
        .done(done), .hit(hit), .multi_hit(multi_hit), .hit_idx(hit_idx),
        .match_vec(match_vec));

    tcam_search_engine #(.ENTRIES(N), .WIDTH(W), .TERNARY(1'b0)) u1 (
        .clk(clk), .rst(rst), .wr_req(b_wr_req), .wr_ready(b_wr_ready),
        .wr_idx(3'd0), .wr_data(b_wr_data), .wr_care(b_wr_care), .wr_valid(1'b1),
        .srch_req(b_srch_req), .srch_ready(b_srch_ready), .srch_key(b_key),
        .done(b_done), .hit(b_hit), .multi_hit(b_multi), .hit_idx(b_idx),
        .match_vec(b_vec));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [W-1:0] m_data [N];
    logic [W-1:0] m_care [N];
    logic         m_valid[N];
    exp_t         sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [W-1:0] key, input string tag);
        exp_t e;
        int   cnt = 0;
        e.vec = '0;
        e.idx = '0;
        for (int i = 0; i < N; i++)
            e.vec[i] = m_valid[i] && (((m_data[i] ^ key) & m_care[i]) == '0);
        for (int i = N - 1; i >= 0; i--)
            if (e.vec[i]) e.idx = 3'(i);
        for (int i = 0; i < N; i++) cnt += int'(e.vec[i]);
        e.hit   = (cnt > 0);
        e.multi = (cnt > 1);
        e.tag   = tag;
        e.due   = 0;
        return e;
    endfunction

    // Monitor: pops the scoreboard on every result pulse.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.due, "R3", {e.tag, " done cycle"}, cyc, e.due);
                chk(hit == e.hit, e.tag, "hit", int'(hit), int'(e.hit));
                chk(multi_hit == e.multi, e.tag, "multi_hit", int'(multi_hit), int'(e.multi));
                chk(hit_idx == e.idx, e.tag, "hit_idx", int'(hit_idx), int'(e.idx));
                chk(match_vec == e.vec, {e.tag, " R10"}, "match_vec", int'(match_vec), int'(e.vec));
            end
        end
    end

    // Driver: request asserted at once, held until the block is idle.
    task automatic do_write(input int idx, input logic [W-1:0] d,
                            input logic [W-1:0] c, input logic v);
        wr_req = 1; wr_idx = 3'(idx); wr_data = d; wr_care = c; wr_valid = v;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        m_data[idx] = d; m_care[idx] = c; m_valid[idx] = v;
        @(negedge clk);
        wr_req = 0;
    endtask

    task automatic search_start(input logic [W-1:0] key, input string tag);
        exp_t e;
        while (!srch_ready) @(negedge clk);
        e     = predict(key, tag);
        e.due = cyc + 5;
        sb.push_back(e);
        srch_req = 1; srch_key = key;
        @(posedge clk);
        @(negedge clk);
        srch_req = 0;
        srch_key = ~key;   // R2: key changes after capture
        chk(!srch_ready && !wr_ready, "R3", "ready low while busy",
            int'({srch_ready, wr_ready}), 0);
    endtask

    task automatic search(input logic [W-1:0] key, input string tag);
        search_start(key, tag);
        while (!srch_ready) @(negedge clk);
    endtask

    task automatic write_and_search(input int idx, input logic [W-1:0] d,
                                    input logic [W-1:0] c, input string tag);
        exp_t e;
        while (!srch_ready) @(negedge clk);
        m_data[idx] = d; m_care[idx] = c; m_valid[idx] = 1'b1;
        e     = predict(d, tag);
        e.due = cyc + 5;
        sb.push_back(e);
        wr_req = 1; wr_idx = 3'(idx); wr_data = d; wr_care = c; wr_valid = 1;
        srch_req = 1; srch_key = d;
        @(posedge clk);
        @(negedge clk);
        wr_req = 0; srch_req = 0; srch_key = ~d;
        while (!srch_ready) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_data[i] = '0; m_care[i] = '0; m_valid[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        chk(wr_ready && srch_ready, "R1", "ready after reset",
            int'({wr_ready, srch_ready}), 3);
        chk(!done && !hit && !multi_hit && hit_idx == 0 && match_vec == 0, "R1",
            "outputs after reset", int'({done, hit, multi_hit, hit_idx, match_vec}), 0);
        search(8'h00, "R1 empty table");

        // R4: exact compare on cared bits
        do_write(2, 8'hA5, 8'hFF, 1);
        search(8'hA5, "R4 exact hit");
        search(8'hA4, "R4 one bit differs");

        // R5: pattern 10XX0 in the low bits
        do_write(5, 8'h10, 8'hF9, 1);
        search(8'h10, "R5 key 10000");
        search(8'h12, "R5 key 10010");
        search(8'h14, "R5 key 10100");
        search(8'h16, "R5 key 10110");
        search(8'h11, "R5 cared lsb differs");
        search(8'h18, "R5 cared bit3 differs");

        // R7: overlapping entries, lowest wins
        do_write(6, 8'h00, 8'h00, 1);
        search(8'h14, "R7 two matches");
        search(8'hA5, "R7 lowest of two");
        search(8'h3C, "R7 single wildcard match");

        // R6: invalidation
        do_write(6, 8'h00, 8'h00, 0);
        search(8'h14, "R6 invalidated entry");
        do_write(1, 8'h33, 8'hFF, 0);
        search(8'h33, "R6 written invalid");

        // R8: total miss
        search(8'hEE, "R8 no match");

        // R2: key scrambled after capture inside search_start
        search(8'h16, "R2 key held");

        // R9: write and search on the same edge
        write_and_search(0, 8'h77, 8'hFF, "R9 same-edge write");
        // R9: write in the done cycle, then search again
        do_write(0, 8'h78, 8'hFF, 1);
        search(8'h77, "R9 old value gone");
        search(8'h78, "R9 new value seen");

        // R9: write requested mid-search is held off
        search_start(8'h55, "R9 search before held write");
        do_write(3, 8'h55, 8'hFF, 1);
        chk(sb.size() == 0, "R9", "held write landed after done", sb.size(), 0);
        search(8'h55, "R9 held write visible");

        // R11: binary configuration ignores care mask
        @(negedge clk);
        b_wr_req = 1; b_wr_data = 8'h0F; b_wr_care = 8'h00;
        @(negedge clk);
        b_wr_req = 0;
        b_srch_req = 1; b_key = 8'hFF;
        @(negedge clk);
        b_srch_req = 0;
        while (!b_done) @(negedge clk);
        chk(!b_hit, "R11", "care ignored, non-exact key", int'(b_hit), 0);
        @(negedge clk);
        b_srch_req = 1; b_key = 8'h0F;
        @(negedge clk);
        b_srch_req = 0;
        while (!b_done) @(negedge clk);
        chk(b_hit && b_idx == 0, "R11", "exact key hits", int'({b_hit, b_idx}), 8);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule